// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers the vertical sync interval from a composite sync stream, for example the digital sync produced by slicing the sync tip off a green video channel. Composite sync carries horizontal pulses, equalization pulses and, during the vertical interval, long serrated pulses. The block works on a fixed 5 MHz sampling clock and tells these apart only by width. It measures how many clock periods the input holds its active level and compares that run length with a programmable threshold. Only runs at least as long as the threshold can move the separated output. The threshold must be set above the widest horizontal or equalization pulse. The register that holds it normally resets to 32.

A small output stage then picks either a raw vertical sync input or the separated sync. It can optionally invert the chosen signal and registers the result. The choice between raw and separated applies only while an override input is set. Otherwise a build-time parameter fixes the source, and by default that source is the separated sync.

Top module: `csync_vsep`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both `sep_vsync_o` and `vsync_o` are 0.
- R2: An active composite sync run shorter than the effective threshold leaves `sep_vsync_o` unchanged, so horizontal and equalization pulses never reach it.
- R3: An active run of L cycles with L >= E sets `sep_vsync_o` to 1, where E = max(T,1) and T is `thresh_i`. Edge 0 is the first clock edge that samples the new input level. The output rises on edge E+2.
- R4: `sep_vsync_o` returns to 0 only after the input has been inactive for E cycles. It falls on edge E+2 after the edge that first samples the inactive level. Inactive gaps shorter than E inside the vertical interval do not clear it.
- R5: The run-length counter saturates at 2^THR_W-1 and does not wrap. A run far longer than the largest threshold still sets the output, and the output still clears normally afterwards.
- R6: With the default `CSYNC_ACTIVE_LOW`=1, a low level on `csync_i` is active and a high level is idle. A long high level never sets `sep_vsync_o`.
- R7: `thresh_i` is used live each cycle. The values 0 and 1 behave the same.
- R8: Source select: when `vs_override_i`=1, `vs_use_sep_i`=0 picks `raw_vsync_i` and `vs_use_sep_i`=1 picks the separated sync. When `vs_override_i`=0, the separated sync is used and `vs_use_sep_i` and `raw_vsync_i` have no effect.
- R9: `vs_invert_i`=1 inverts the selected sync and `vs_invert_i`=0 passes it unchanged.
- R10: `vsync_o` is registered. It follows the selected and inverted source one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_i | input | 1 | Composite sync, asynchronous to clk |
| thresh_i | input | THR_W | Width threshold in clock periods |
| raw_vsync_i | input | 1 | Unseparated vertical sync |
| vs_override_i | input | 1 | 1: the source select input is honoured |
| vs_use_sep_i | input | 1 | Source select: 0 raw, 1 separated |
| vs_invert_i | input | 1 | 1: invert the output sync |
| sep_vsync_o | output | 1 | Separated vertical sync, active high |
| vsync_o | output | 1 | Selected, optionally inverted, registered vertical sync |

## Verification
Counting the first edge that samples a changed `csync_i` as edge 0, `sep_vsync_o` moves on edge E+2 and `vsync_o` moves on edge E+3. A change on the raw input, the select inputs or the invert input reaches `vsync_o` on the next edge. The bench changes inputs on falling edges and samples on every later falling edge. It records the exact sample index at which each output first rises and falls, and compares that index with the value computed from L and E. This makes an off-by-one in the latency, or in the width comparison, show up as a wrong index rather than slipping through a loose window. Pulses exactly one cycle shorter than E and exactly equal to E are in the vector table.

// File: rtl/csv_pkg.sv
package csv_pkg;

   typedef enum logic {
      VS_RAW = 1'b0,
      VS_SEP = 1'b1
   } vs_src_e;

   // Source chosen for the output stage; the select input only counts under override.
   function automatic vs_src_e pick_src(input logic ovr, input logic use_sep, input logic auto_sep);
      logic choose_sep;
      choose_sep = ovr ? use_sep : auto_sep;
      return choose_sep ? VS_SEP : VS_RAW;
   endfunction

endpackage

// File: rtl/csv_sync.sv
module csv_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("csv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/csv_width_cnt.sv
module csv_width_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   output logic             lvl_q_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flip;

   assign flip = lvl_i ^ lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         lvl_q <= lvl_i;
         if (flip)                 cnt_q <= CNT_ONE;
         else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign lvl_q_o = lvl_q;
   assign cnt_o   = cnt_q;

   // R2: every level change restarts the run measurement
   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (cnt_q == CNT_ONE));

   // R5: a full count is held while the level stays put
   assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !flip) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/csv_slicer.sv
module csv_slicer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             sep_o
);

   logic sep_q;
   logic long_run;

   assign long_run = (cnt_i >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sep_q <= 1'b0;
      else if (long_run) sep_q <= lvl_i;
   end

   assign sep_o = sep_q;

   // R2: a run still under the threshold cannot move the separated sync
   assert_short_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i < thr_i) |=> $stable(sep_q));

endmodule

// File: rtl/csv_out_sel.sv
module csv_out_sel
   import csv_pkg::*;
#(
   parameter bit OUT_REG  = 1'b1,
   parameter bit AUTO_SEP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic sep_i,
   input  logic ovr_i,
   input  logic use_sep_i,
   input  logic inv_i,
   output logic vs_o
);

   vs_src_e src;
   logic    picked;

   assign src    = pick_src(ovr_i, use_sep_i, AUTO_SEP);
   assign picked = ((src == VS_SEP) ? sep_i : raw_i) ^ inv_i;

   generate
      if (OUT_REG) begin : g_reg
         logic vs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vs_q <= 1'b0;
            else        vs_q <= picked;
         end
         assign vs_o = vs_q;

         // R8: override with select 0 forwards the raw sync
         assert_raw_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr_i && !use_sep_i && !inv_i) |=> (vs_q == $past(raw_i)));

         // R9: invert flips the separated sync
         assert_invert_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr_i && use_sep_i && inv_i) |=> (vs_q == !$past(sep_i)));
      end else begin : g_comb
         assign vs_o = picked;
      end
   endgenerate

endmodule

// File: rtl/csync_vsep.sv
module csync_vsep #(
   parameter int THR_W            = 8,
   parameter int SYNC_STAGES      = 2,
   parameter bit CSYNC_ACTIVE_LOW = 1'b1,
   parameter bit AUTO_SEP         = 1'b1,
   parameter bit OUT_REG          = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync_i,
   input  logic [THR_W-1:0] thresh_i,
   input  logic             raw_vsync_i,
   input  logic             vs_override_i,
   input  logic             vs_use_sep_i,
   input  logic             vs_invert_i,
   output logic             sep_vsync_o,
   output logic             vsync_o
);

   localparam logic IDLE_LVL = CSYNC_ACTIVE_LOW;

   generate
      if (THR_W < 2 || THR_W > 16) begin : g_bad_width
         $error("csync_vsep: THR_W must lie in 2..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("csync_vsep: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             cs_sync;
   logic             cs_act;
   logic             lvl_q;
   logic [THR_W-1:0] run_cnt;
   logic             sep_vs;

   csv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (csync_i),
      .q_o   (cs_sync)
   );

   generate
      if (CSYNC_ACTIVE_LOW) begin : g_act_low
         assign cs_act = ~cs_sync;
      end else begin : g_act_high
         assign cs_act = cs_sync;
      end
   endgenerate

   csv_width_cnt #(.CNT_W(THR_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (cs_act),
      .lvl_q_o (lvl_q),
      .cnt_o   (run_cnt)
   );

   csv_slicer #(.CNT_W(THR_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl_q),
      .cnt_i (run_cnt),
      .thr_i (thresh_i),
      .sep_o (sep_vs)
   );

   csv_out_sel #(.OUT_REG(OUT_REG), .AUTO_SEP(AUTO_SEP)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (raw_vsync_i),
      .sep_i     (sep_vs),
      .ovr_i     (vs_override_i),
      .use_sep_i (vs_use_sep_i),
      .inv_i     (vs_invert_i),
      .vs_o      (vsync_o)
   );

   assign sep_vsync_o = sep_vs;

   // R3: the separated sync only rises out of an active run
   assert_rise_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sep_vs) |-> $past(lvl_q));

   // R4: the separated sync only falls out of an idle run
   assert_fall_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sep_vs) |-> !$past(lvl_q));

endmodule

// File: tb/csync_vsep_test.sv
module csync_vsep_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csync_i = 1'b1;
   logic [7:0] thresh_i = 8'd32;
   logic       raw_vsync_i = 1'b0;
   logic       vs_override_i = 1'b1;
   logic       vs_use_sep_i = 1'b1;
   logic       vs_invert_i = 1'b0;
   logic       sep_vsync_o;
   logic       vsync_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   csync_vsep uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .csync_i       (csync_i),
      .thresh_i      (thresh_i),
      .raw_vsync_i   (raw_vsync_i),
      .vs_override_i (vs_override_i),
      .vs_use_sep_i  (vs_use_sep_i),
      .vs_invert_i   (vs_invert_i),
      .sep_vsync_o   (sep_vsync_o),
      .vsync_o       (vsync_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0]  thr;
      logic [15:0] len;
   } vec_t;

   // R2 short pulses, R3 long pulses, R5 beyond counter range, R7 threshold 0 and 1
   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'd32,  16'd10},
      '{8'd32,  16'd31},
      '{8'd32,  16'd32},
      '{8'd32,  16'd40},
      '{8'd5,   16'd4},
      '{8'd5,   16'd5},
      '{8'd1,   16'd1},
      '{8'd0,   16'd1},
      '{8'd255, 16'd254},
      '{8'd255, 16'd300},
      '{8'd200, 16'd255}
   };

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 sep in reset", sep_vsync_o, 0);
      chk("R1 vsync in reset", vsync_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sep after reset", sep_vsync_o, 0);
      chk("R1 vsync after reset", vsync_o, 0);
      repeat (4) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         int eff, len, win, s_hi, s_lo, o_hi, o_lo;
         thresh_i = VECS[v].thr;
         len = int'(VECS[v].len);
         eff = (VECS[v].thr == 8'd0) ? 1 : int'(VECS[v].thr);
         win = len + eff + 10;
         s_hi = -1; s_lo = -1; o_hi = -1; o_lo = -1;
         repeat (4) @(negedge clk);
         for (int i = 0; i <= win; i++) begin
            if (i == 0)   csync_i = 1'b0;
            if (i == len) csync_i = 1'b1;
            if (sep_vsync_o === 1'b1 && s_hi < 0) s_hi = i;
            if (sep_vsync_o === 1'b0 && s_hi >= 0 && s_lo < 0) s_lo = i;
            if (vsync_o === 1'b1 && o_hi < 0) o_hi = i;
            if (vsync_o === 1'b0 && o_hi >= 0 && o_lo < 0) o_lo = i;
            @(negedge clk);
         end
         if (len >= eff) begin
            chk("R3 separated rise index", s_hi, eff + 3);
            chk("R4 separated fall index", s_lo, len + eff + 3);
            chk("R10 output rise index", o_hi, eff + 4);
            chk("R10 output fall index", o_lo, len + eff + 4);
         end else begin
            chk("R2 short pulse ignored", s_hi, -1);
            chk("R2 short pulse output", o_hi, -1);
         end
      end

      // R4: serration gaps shorter than the threshold keep the sync asserted
      begin
         int held_ok, fall_at;
         thresh_i = 8'd20;
         held_ok = 1; fall_at = -1;
         repeat (4) @(negedge clk);
         for (int i = 0; i <= 170; i++) begin
            if (i == 0)   csync_i = 1'b0;
            if (i == 60)  csync_i = 1'b1;
            if (i == 70)  csync_i = 1'b0;
            if (i == 130) csync_i = 1'b1;
            if (i >= 23 && i <= 152 && sep_vsync_o !== 1'b1) held_ok = 0;
            if (i > 23 && sep_vsync_o === 1'b0 && fall_at < 0) fall_at = i;
            @(negedge clk);
         end
         chk("R4 held through serration gap", held_ok, 1);
         chk("R4 fall after final idle run", fall_at, 153);
      end

      // R6: a long idle-high level never sets the separated sync
      begin
         int seen;
         seen = 0;
         thresh_i = 8'd3;
         csync_i = 1'b1;
         for (int i = 0; i < 300; i++) begin
            if (sep_vsync_o !== 1'b0) seen = 1;
            @(negedge clk);
         end
         chk("R6 high level is idle", seen, 0);
      end

      // R8 / R10: raw path, registered one edge later
      vs_override_i = 1'b1; vs_use_sep_i = 1'b0; vs_invert_i = 1'b0;
      @(negedge clk);
      raw_vsync_i = 1'b1;
      #1 chk("R10 no change before edge", vsync_o, 0);
      @(negedge clk);
      chk("R8 raw selected high", vsync_o, 1);
      raw_vsync_i = 1'b0;
      @(negedge clk);
      chk("R8 raw selected low", vsync_o, 0);

      // R9: invert on the raw path
      vs_invert_i = 1'b1;
      @(negedge clk);
      chk("R9 invert raw low", vsync_o, 1);
      vs_invert_i = 1'b0;
      @(negedge clk);
      chk("R9 invert cleared", vsync_o, 0);

      // R8: without override the separated sync is used and raw/select are ignored
      vs_override_i = 1'b0; vs_use_sep_i = 1'b0; raw_vsync_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 auto source ignores raw", vsync_o, 0);
      chk("R8 separated still idle", sep_vsync_o, 0);
      vs_invert_i = 1'b1;
      @(negedge clk);
      chk("R9 invert separated", vsync_o, 1);
      vs_invert_i = 1'b0;
      raw_vsync_i = 1'b0;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule